// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Datapath

This block is a signed fixed-point arithmetic unit that sits next to a scalar integer pipeline. It takes two 32-bit operands read from a shared register file, along with a 4-bit operation code. Its results go into two private accumulators: a 32-bit accumulator and a 64-bit accumulator. Because it never writes the general registers, it can work while the integer ALU and the load/store path keep issuing.

Most operations finish in one cycle. There are two kinds of 16-bit operation: real operations use the low halfword of each operand, and complex operations treat each operand as a packed pair of 16-bit numbers. The 32x32 operations run through a one-stage product pipeline. While such an operation is in flight, the unit holds `busy` high and drops `issue_ready`. Both accumulators are visible at the ports at all times.

Top module: `dsp_mac_unit`

## Requirements
- R1: After a synchronous active-high reset, acc32 and acc64 are zero, busy is low and issue_ready is high.
- R2: Opcode 0x0 replaces acc32 with the signed product of issue_a[15:0] and issue_b[15:0]. The new value is visible after the first rising edge that accepts the issue.
- R3: Opcode 0x1 adds that 16x16 signed product to acc32, and opcode 0x2 subtracts it from acc32. Both wrap modulo 2^32 and take effect after one edge.
- R4: Opcode 0x3 replaces acc64 with the signed 64-bit product of issue_a and issue_b. busy is high for exactly the one cycle after the accepting edge, and the result is visible after the second edge.
- R5: Opcode 0x4 adds the signed 32x32 product to acc64, and opcode 0x5 subtracts it. Both wrap modulo 2^64 and follow the same two-cycle timing as R4.
- R6: Complex operands carry the real part in bits [31:16] and the imaginary part in bits [15:0]. The complex product is re = ar*br - ai*bi and im = ar*bi + ai*br, each wrapped to 32 bits. Opcode 0x6 writes {re, im} to acc64, with re in bits [63:32]. Opcode 0x7 adds re and im to the upper and lower halves separately, and opcode 0x8 subtracts them. There is no carry between the halves.
- R7: Opcode 0x9 writes to acc32 the lane-wise 16-bit sums of the packed halves of the two operands, keeping the same lane positions. Opcode 0xA writes the lane-wise differences a minus b. Each lane wraps modulo 2^16.
- R8: Opcode 0xB writes to acc32 the number of leading zero bits of issue_a. An all-zero operand gives 32.
- R9: An issue presented while busy is high, an issue with opcode 0xC to 0xF, and a cycle with issue_valid low all leave both accumulators unchanged.
- R10: Operations that target acc32 (0x0 to 0x2, 0x9 to 0xB) leave acc64 unchanged. Operations that target acc64 (0x3 to 0x8) leave acc32 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Operation presented this cycle |
| issue_op | input | 4 | Operation code |
| issue_a | input | 32 | First operand |
| issue_b | input | 32 | Second operand |
| issue_ready | output | 1 | Unit can accept an issue this cycle |
| busy | output | 1 | 32x32 operation in flight |
| acc32 | output | 32 | 32-bit accumulator |
| acc64 | output | 64 | 64-bit accumulator |

## Verification
The assertions assume that the issue inputs are driven to known values outside reset. They do not assume that the issuer respects issue_ready: the ignore rule for busy cycles is itself asserted. The stimulus drives all sixteen opcode values, including the unused ones. It mixes random operands with the extreme halfword and word values that exercise wraparound. On purpose, it also presents a second issue during the busy cycle, so that the ignore path is covered.

// File: rtl/dspmac_pkg.sv
package dspmac_pkg;

    localparam int DW = 32;
    localparam int HW = DW / 2;
    localparam int AW = 2 * DW;
    localparam int CW = $clog2(DW) + 1;

    typedef enum logic [3:0] {
        OP_MUL_H   = 4'h0,
        OP_MAC_H   = 4'h1,
        OP_MSU_H   = 4'h2,
        OP_MUL_W   = 4'h3,
        OP_MAC_W   = 4'h4,
        OP_MSU_W   = 4'h5,
        OP_CMUL    = 4'h6,
        OP_CMAC    = 4'h7,
        OP_CMSU    = 4'h8,
        OP_CADD    = 4'h9,
        OP_CSUB    = 4'hA,
        OP_LZC     = 4'hB,
        OP_RSV_C   = 4'hC,
        OP_RSV_D   = 4'hD,
        OP_RSV_E   = 4'hE,
        OP_RSV_F   = 4'hF
    } dsp_op_e;

    typedef enum logic [1:0] {
        ACC_SET = 2'd0,
        ACC_ADD = 2'd1,
        ACC_SUB = 2'd2
    } acc_mode_e;

    typedef struct packed {
        logic [DW-1:0] re;
        logic [DW-1:0] im;
    } cplx_t;

    typedef struct packed {
        logic          wr;
        acc_mode_e     mode;
        logic [DW-1:0] val;
    } narrow_req_t;

    typedef struct packed {
        logic          wr;
        acc_mode_e     mode;
        logic          split;
        logic [AW-1:0] val;
    } wide_req_t;

    // Signed halfword product kept modulo 2^DW.
    function automatic logic [DW-1:0] mul_half(input logic [HW-1:0] x,
                                               input logic [HW-1:0] y);
        logic [DW-1:0] xe;
        logic [DW-1:0] ye;
        xe = {{HW{x[HW-1]}}, x};
        ye = {{HW{y[HW-1]}}, y};
        return xe * ye;
    endfunction

    function automatic logic [CW-1:0] lead_zeros(input logic [DW-1:0] x);
        logic [CW-1:0] n;
        logic          seen;
        n    = '0;
        seen = 1'b0;
        for (int i = DW - 1; i >= 0; i--) begin
            if (!seen) begin
                if (x[i]) seen = 1'b1;
                else      n = n + 1'b1;
            end
        end
        return n;
    endfunction

    function automatic logic is_wide_op(input dsp_op_e op);
        return (op == OP_MUL_W) || (op == OP_MAC_W) || (op == OP_MSU_W);
    endfunction

    function automatic acc_mode_e mode_of(input dsp_op_e op);
        case (op)
            OP_MAC_H, OP_MAC_W, OP_CMAC: return ACC_ADD;
            OP_MSU_H, OP_MSU_W, OP_CMSU: return ACC_SUB;
            default:                     return ACC_SET;
        endcase
    endfunction

endpackage

// File: rtl/dspmac_wide_mul.sv
module dspmac_wide_mul
    import dspmac_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  acc_mode_e              mode_i,
    input  logic [DW-1:0]          a,
    input  logic [DW-1:0]          b,
    output logic                   vld_o,
    output acc_mode_e              mode_o,
    output logic [AW-1:0]          prod_o
);
    logic [AW-1:0] ae;
    logic [AW-1:0] be;

    always_comb begin
        ae = {{DW{a[DW-1]}}, a};
        be = {{DW{b[DW-1]}}, b};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o  <= 1'b0;
            mode_o <= ACC_SET;
            prod_o <= '0;
        end else begin
            vld_o <= start;
            if (start) begin
                mode_o <= mode_i;
                prod_o <= ae * be;
            end
        end
    end
endmodule

// File: rtl/dspmac_cplx.sv
module dspmac_cplx
    import dspmac_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output cplx_t         prod,
    output logic [DW-1:0] lane_sum,
    output logic [DW-1:0] lane_dif
);
    logic [HW-1:0] ar, ai, br, bi;

    always_comb begin
        ar = a[DW-1:HW];
        ai = a[HW-1:0];
        br = b[DW-1:HW];
        bi = b[HW-1:0];
        prod.re = mul_half(ar, br) - mul_half(ai, bi);
        prod.im = mul_half(ar, bi) + mul_half(ai, br);
    end

    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign lane_sum[g*HW +: HW] = a[g*HW +: HW] + b[g*HW +: HW];
        assign lane_dif[g*HW +: HW] = a[g*HW +: HW] - b[g*HW +: HW];
    end
endmodule

// File: rtl/dspmac_acc.sv
module dspmac_acc
    import dspmac_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  narrow_req_t   nreq,
    input  wide_req_t     wreq,
    output logic [DW-1:0] acc32_q,
    output logic [AW-1:0] acc64_q
);
    logic [DW-1:0] n_next;
    logic [AW-1:0] w_next;
    logic [DW-1:0] hi_cur, lo_cur, hi_in, lo_in;

    always_comb begin
        case (nreq.mode)
            ACC_ADD: n_next = acc32_q + nreq.val;
            ACC_SUB: n_next = acc32_q - nreq.val;
            default: n_next = nreq.val;
        endcase
    end

    always_comb begin
        hi_cur = acc64_q[AW-1:DW];
        lo_cur = acc64_q[DW-1:0];
        hi_in  = wreq.val[AW-1:DW];
        lo_in  = wreq.val[DW-1:0];
        case (wreq.mode)
            ACC_ADD: w_next = wreq.split ? {hi_cur + hi_in, lo_cur + lo_in}
                                         : acc64_q + wreq.val;
            ACC_SUB: w_next = wreq.split ? {hi_cur - hi_in, lo_cur - lo_in}
                                         : acc64_q - wreq.val;
            default: w_next = wreq.val;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc32_q <= '0;
            acc64_q <= '0;
        end else begin
            if (nreq.wr) acc32_q <= n_next;
            if (wreq.wr) acc64_q <= w_next;
        end
    end
endmodule

// File: rtl/dsp_mac_unit.sv
module dsp_mac_unit
    import dspmac_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          issue_valid,
    input  logic [3:0]    issue_op,
    input  logic [31:0]   issue_a,
    input  logic [31:0]   issue_b,
    output logic          issue_ready,
    output logic          busy,
    output logic [31:0]   acc32,
    output logic [63:0]   acc64
);
    dsp_op_e       op;
    logic          accept;
    logic          wide_vld;
    acc_mode_e     wide_mode;
    logic [AW-1:0] wide_prod;
    cplx_t         cprod;
    logic [DW-1:0] lane_sum, lane_dif;
    narrow_req_t   nreq;
    wide_req_t     wreq;

    assign op          = dsp_op_e'(issue_op);
    assign busy        = wide_vld;
    assign issue_ready = !wide_vld;
    assign accept      = issue_valid && !wide_vld;

    dspmac_wide_mul u_wmul (
        .clk    (clk),
        .rst    (rst),
        .start  (accept && is_wide_op(op)),
        .mode_i (mode_of(op)),
        .a      (issue_a),
        .b      (issue_b),
        .vld_o  (wide_vld),
        .mode_o (wide_mode),
        .prod_o (wide_prod)
    );

    dspmac_cplx u_cplx (
        .a        (issue_a),
        .b        (issue_b),
        .prod     (cprod),
        .lane_sum (lane_sum),
        .lane_dif (lane_dif)
    );

    always_comb begin
        nreq = '{wr: 1'b0, mode: ACC_SET, val: '0};
        if (accept) begin
            case (op)
                OP_MUL_H, OP_MAC_H, OP_MSU_H: begin
                    nreq.wr   = 1'b1;
                    nreq.mode = mode_of(op);
                    nreq.val  = mul_half(issue_a[HW-1:0], issue_b[HW-1:0]);
                end
                OP_CADD: nreq = '{wr: 1'b1, mode: ACC_SET, val: lane_sum};
                OP_CSUB: nreq = '{wr: 1'b1, mode: ACC_SET, val: lane_dif};
                OP_LZC: begin
                    nreq.wr  = 1'b1;
                    nreq.val = DW'(lead_zeros(issue_a));
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        wreq = '{wr: 1'b0, mode: ACC_SET, split: 1'b0, val: '0};
        if (wide_vld) begin
            wreq = '{wr: 1'b1, mode: wide_mode, split: 1'b0, val: wide_prod};
        end else if (accept && (op == OP_CMUL || op == OP_CMAC || op == OP_CMSU)) begin
            wreq = '{wr: 1'b1, mode: mode_of(op), split: 1'b1, val: cprod};
        end
    end

    dspmac_acc u_acc (
        .clk     (clk),
        .rst     (rst),
        .nreq    (nreq),
        .wreq    (wreq),
        .acc32_q (acc32),
        .acc64_q (acc64)
    );
endmodule

// File: rtl/dspmac_checks.sv
module dspmac_checks (
    input logic        clk,
    input logic        rst,
    input logic        issue_valid,
    input logic [3:0]  issue_op,
    input logic        issue_ready,
    input logic        busy,
    input logic [31:0] acc32,
    input logic [63:0] acc64
);
    logic taken;
    assign taken = issue_valid && issue_ready;

    // R4: a wide multiply holds busy for one cycle only
    a_r4_busy_after_wide: assert property (@(posedge clk) disable iff (rst)
        (taken && issue_op inside {4'h3, 4'h4, 4'h5}) |=> busy);
    a_r4_busy_single: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

    // R9: nothing is accepted into acc32 while busy, and idle cycles change nothing
    a_r9_busy_blocks_narrow: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(acc32));
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!issue_valid && !busy) |=> ($stable(acc32) && $stable(acc64)));
    a_r9_reserved_hold: assert property (@(posedge clk) disable iff (rst)
        (taken && issue_op inside {4'hC, 4'hD, 4'hE, 4'hF}) |=> ($stable(acc32) && $stable(acc64)));

    // R10: narrow operations leave acc64 alone; complex ones leave acc32 alone
    a_r10_narrow_keeps_wide: assert property (@(posedge clk) disable iff (rst)
        (taken && issue_op inside {4'h0, 4'h1, 4'h2, 4'h9, 4'hA, 4'hB}) |=> $stable(acc64));
    a_r10_cplx_keeps_narrow: assert property (@(posedge clk) disable iff (rst)
        (taken && issue_op inside {4'h6, 4'h7, 4'h8}) |=> $stable(acc32));

    // R8: leading-zero count never exceeds the word width
    a_r8_lzc_range: assert property (@(posedge clk) disable iff (rst)
        (taken && issue_op == 4'hB) |=> (acc32 <= 32'd32));

    // R1: ready is the complement of busy
    a_r1_ready_busy: assert property (@(posedge clk) disable iff (rst)
        issue_ready != busy);
endmodule

bind dsp_mac_unit dspmac_checks u_checks (
    .clk         (clk),
    .rst         (rst),
    .issue_valid (issue_valid),
    .issue_op    (issue_op),
    .issue_ready (issue_ready),
    .busy        (busy),
    .acc32       (acc32),
    .acc64       (acc64)
);

// File: tb/sim_dsp_mac_unit.sv
module sim_dsp_mac_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid = 1'b0;
    logic [3:0]  issue_op = 4'h0;
    logic [31:0] issue_a = '0;
    logic [31:0] issue_b = '0;
    logic        issue_ready, busy;
    logic [31:0] acc32;
    logic [63:0] acc64;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [31:0] m32 = '0;
    logic [63:0] m64 = '0;

    always #2 clk = ~clk;

    dsp_mac_unit u0 (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_a(issue_a), .issue_b(issue_b), .issue_ready(issue_ready),
        .busy(busy), .acc32(acc32), .acc64(acc64)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'h0: return "R2";
            4'h1, 4'h2: return "R3";
            4'h3: return "R4";
            4'h4, 4'h5: return "R5";
            4'h6, 4'h7, 4'h8: return "R6";
            4'h9, 4'hA: return "R7";
            4'hB: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic int p16(input logic [15:0] x, input logic [15:0] y);
        return int'(shortint'(x)) * int'(shortint'(y));
    endfunction

    function automatic int lzc(input logic [31:0] x);
        for (int i = 31; i >= 0; i--) if (x[i]) return 31 - i;
        return 32;
    endfunction

    task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        longint w;
        int re, im;
        w  = longint'(int'(a)) * longint'(int'(b));
        re = p16(a[31:16], b[31:16]) - p16(a[15:0], b[15:0]);
        im = p16(a[31:16], b[15:0]) + p16(a[15:0], b[31:16]);
        case (op)
            4'h0: m32 = p16(a[15:0], b[15:0]);
            4'h1: m32 = m32 + p16(a[15:0], b[15:0]);
            4'h2: m32 = m32 - p16(a[15:0], b[15:0]);
            4'h3: m64 = w;
            4'h4: m64 = m64 + w;
            4'h5: m64 = m64 - w;
            4'h6: m64 = {re, im};
            4'h7: m64 = {m64[63:32] + re, m64[31:0] + im};
            4'h8: m64 = {m64[63:32] - re, m64[31:0] - im};
            4'h9: m32 = {a[31:16] + b[31:16], a[15:0] + b[15:0]};
            4'hA: m32 = {a[31:16] - b[31:16], a[15:0] - b[15:0]};
            4'hB: m32 = lzc(a);
            default: ;
        endcase
    endtask

    task automatic run_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        issue_valid = 1'b1; issue_op = op; issue_a = a; issue_b = b;
        @(negedge clk);
        issue_valid = 1'b0;
        model(op, a, b);
        if (op inside {4'h3, 4'h4, 4'h5}) begin
            chk("R4 busy during wide op", 64'(busy), 64'd1);
            @(negedge clk);
            chk("R4 busy clears", 64'(busy), 64'd0);
        end
        chk({tag_of(op), " acc32 (R10)"}, 64'(acc32), 64'(m32));
        chk({tag_of(op), " acc64 (R10)"}, acc64, m64);
    endtask

    function automatic logic [31:0] pick();
        case ($urandom % 7)
            0: return 32'h8000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h8000_8000;
            3: return 32'h7FFF_7FFF;
            4: return 32'h0;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 acc32", 64'(acc32), 64'd0);
        chk("R1 acc64", acc64, 64'd0);
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 ready", 64'(issue_ready), 64'd1);

        // directed corners
        run_op(4'h0, 32'h0000_8000, 32'h0000_8000);   // R2
        run_op(4'h1, 32'h1234_7FFF, 32'hABCD_7FFF);   // R3
        run_op(4'h2, 32'h0000_FFFF, 32'h0000_0003);   // R3
        run_op(4'h3, 32'h8000_0000, 32'h8000_0000);   // R4
        run_op(4'h5, 32'h7FFF_FFFF, 32'h8000_0000);   // R5
        run_op(4'h4, 32'hFFFF_FFFF, 32'h0000_0005);   // R5
        run_op(4'h6, 32'h8000_8000, 32'h8000_8000);   // R6 wrap of re/im
        run_op(4'h7, 32'h0003_FFFE, 32'h0002_0004);   // R6
        run_op(4'h8, 32'h7FFF_8000, 32'h8000_7FFF);   // R6
        run_op(4'h9, 32'h7FFF_FFFF, 32'h0001_0001);   // R7 lane wrap
        run_op(4'hA, 32'h8000_0000, 32'h0001_0001);   // R7
        run_op(4'hB, 32'h0000_0000, 32'h0);           // R8 zero gives 32
        run_op(4'hB, 32'h0000_0001, 32'h0);           // R8
        run_op(4'hB, 32'h8000_0000, 32'h0);           // R8
        run_op(4'hF, 32'hDEAD_BEEF, 32'h1234_5678);   // R9 reserved code

        // R9: issue during busy is dropped
        @(negedge clk);
        issue_valid = 1'b1; issue_op = 4'h3; issue_a = 32'h0001_0003; issue_b = 32'hFFFF_FFF0;
        @(negedge clk);
        model(4'h3, 32'h0001_0003, 32'hFFFF_FFF0);
        issue_op = 4'h0; issue_a = 32'h0000_0077; issue_b = 32'h0000_0011;
        @(negedge clk);
        issue_valid = 1'b0;
        chk("R9 acc32 after busy issue", 64'(acc32), 64'(m32));
        chk("R4 acc64 after busy issue", acc64, m64);
        chk("R9 ready restored", 64'(issue_ready), 64'd1);

        // R9: idle cycles hold
        repeat (3) @(negedge clk);
        chk("R9 idle acc32", 64'(acc32), 64'(m32));
        chk("R9 idle acc64", acc64, m64);

        // constrained random
        for (int n = 0; n < 400; n++) begin
            logic [3:0] op;
            op = 4'($urandom % 16);
            run_op(op, pick(), pick());
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule